// File: doc/BRIEF.md
# Two-Stage Masked Pattern Trigger

This block watches a stream of 64-bit samples and raises a trigger when two chosen patterns show up on consecutive qualified samples. A sample counts only when its sample-enable is high. Each comparison looks only at the bit positions selected by one shared mask. The first pattern is tested first. After it matches, the next qualified sample is tested against the second pattern. If that second test fails, the search goes back to the first pattern.

Software or a control block arms the detector with a one-cycle strobe. On that cycle the two patterns and the mask are captured. A one-cycle cancel strobe returns the detector to idle. When the second pattern matches, the block emits a one-cycle trigger pulse, which a capture engine can use to start recording. The detector then stays in its fired state until it is armed again.

Top module: `seq_pattern_trigger`

## Requirements
- R1: After reset, `trig_state` is 0 (idle) and `trig_pulse` is 0. State codes are: 0 idle, 1 waiting for first pattern, 2 waiting for second pattern, 3 fired.
- R2: An `arm` strobe without `cancel` sets `trig_state` to 1 on the next cycle. In idle, samples have no effect.
- R3: A pattern matches when every bit whose `cmp_mask` bit is 1 equals the pattern bit. Bits whose mask bit is 0 are not compared.
- R4: In state 1, a qualified sample (`smp_valid`=1) that matches `pat0` moves the state to 2. A qualified sample that does not match leaves the state at 1.
- R5: A cycle with `smp_valid`=0 changes neither state nor pulse.
- R6: In state 2, a qualified sample that matches `pat1` moves the state to 3 and raises `trig_pulse` for exactly one cycle, the first cycle of state 3.
- R7: In state 2, a qualified sample that misses `pat1` returns the state to 1. That sample is not tested against `pat0`.
- R8: The same mask governs both the first-pattern test and the second-pattern test.
- R9: State 3 holds, with no further pulse, whatever the samples are, until an `arm` strobe. That strobe moves it to state 1.
- R10: A `cancel` strobe sets the state to 0 on the next cycle from any state. `cancel` wins over an `arm` strobe in the same cycle.
- R11: `pat0`, `pat1` and `cmp_mask` are captured on the `arm` cycle. Later changes to them have no effect until the next arm.
- R12: With an all-zero mask, the trigger fires on the second qualified sample after arming.
- R13: An `arm` strobe during a search (state 1 or 2) restarts the search at state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_data | input | 64 | Sample vector under observation |
| smp_valid | input | 1 | Qualifies `smp_data` for comparison |
| pat0 | input | 64 | First-stage compare pattern |
| pat1 | input | 64 | Second-stage compare pattern |
| cmp_mask | input | 64 | Shared compare mask, 1 selects a bit |
| arm | input | 1 | Strobe: capture configuration and start the search |
| cancel | input | 1 | Strobe: stop and return to idle |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_state | output | 2 | Detector state code |

## Verification
Every result here comes from one register stage. A strobe or a qualified sample presented before a clock edge appears in `trig_state` right after that edge. The trigger pulse appears on the same edge as the state change to 3 and is gone one edge later. The bench drives inputs and samples outputs 2 ns after each rising edge, so each check observes the edge that consumed the stimulus. The internal reset synchronizer adds two cycles after reset release, and the bench waits those out before any stimulus. The pulse width and the holding of state on invalid or post-fire cycles are checked on the cycles that follow.

// File: rtl/strig_pkg.sv
package strig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STAGE0 = 2'd1,
    ST_STAGE1 = 2'd2,
    ST_FIRED  = 2'd3
  } strig_state_e;

  localparam int unsigned NSTAGE = 2;
endpackage

// File: rtl/strig_rst_sync.sv
module strig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/strig_cfg_hold.sv
module strig_cfg_hold #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NSTAGE = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NSTAGE-1:0][DATA_W-1:0] pats_in,
  input  logic [DATA_W-1:0]             mask_in,
  output logic [NSTAGE-1:0][DATA_W-1:0] pats_q,
  output logic [DATA_W-1:0]             mask_q
);
  // captured only on arm so a running search sees a stable setup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pats_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      pats_q <= pats_in;
      mask_q <= mask_in;
    end
  end
endmodule

// File: rtl/strig_match.sv
module strig_match #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] mask,
  output logic              hit
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff = (data ^ pat) & mask;
    hit  = ~|diff;
  end
endmodule

// File: rtl/strig_fsm.sv
module strig_fsm
  import strig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       cancel,
  input  logic       smp_valid,
  input  logic       hit0,
  input  logic       hit1,
  output logic [1:0] state_o,
  output logic       fire_o
);
  strig_state_e state_q, state_d;
  logic         fire_q, fire_d;

  always_comb begin
    state_d = state_q;
    fire_d  = 1'b0;
    if (cancel) begin
      state_d = ST_IDLE;
    end else if (arm) begin
      state_d = ST_STAGE0;
    end else begin
      unique case (state_q)
        ST_STAGE0: if (smp_valid && hit0) state_d = ST_STAGE1;
        ST_STAGE1: begin
          if (smp_valid) begin
            if (hit1) begin
              state_d = ST_FIRED;
              fire_d  = 1'b1;
            end else begin
              state_d = ST_STAGE0;
            end
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
    end
  end

  assign state_o = state_q;
  assign fire_o  = fire_q;
endmodule

// File: rtl/seq_pattern_trigger.sv
module seq_pattern_trigger
  import strig_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] pat0,
  input  logic [DATA_W-1:0] pat1,
  input  logic [DATA_W-1:0] cmp_mask,
  input  logic              arm,
  input  logic              cancel,
  output logic              trig_pulse,
  output logic [1:0]        trig_state
);
  logic                          rst_sync_n;
  logic [NSTAGE-1:0][DATA_W-1:0] pats_in, pats_q;
  logic [DATA_W-1:0]             mask_q;
  logic [NSTAGE-1:0]             hit;

  assign pats_in[0] = pat0;
  assign pats_in[1] = pat1;

  strig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strig_cfg_hold #(.DATA_W(DATA_W), .NSTAGE(NSTAGE)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (arm),
    .pats_in (pats_in),
    .mask_in (cmp_mask),
    .pats_q  (pats_q),
    .mask_q  (mask_q)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    strig_match #(.DATA_W(DATA_W)) u_match (
      .data (smp_data),
      .pat  (pats_q[g]),
      .mask (mask_q),
      .hit  (hit[g])
    );
  end

  strig_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .arm       (arm),
    .cancel    (cancel),
    .smp_valid (smp_valid),
    .hit0      (hit[0]),
    .hit1      (hit[1]),
    .state_o   (trig_state),
    .fire_o    (trig_pulse)
  );
endmodule

// File: rtl/seq_pattern_trigger_chk.sv
module seq_pattern_trigger_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       arm,
  input logic       cancel,
  input logic       smp_valid,
  input logic       trig_pulse,
  input logic [1:0] trig_state
);
  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cancel |=> trig_state == 2'd0); // R10

  AST_ARM_STAGE0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (arm && !cancel) |=> trig_state == 2'd1); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig_pulse |=> !trig_pulse); // R6

  AST_PULSE_IN_FIRED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig_pulse |-> trig_state == 2'd3); // R6

  AST_FIRED_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trig_state == 2'd3 && !arm && !cancel) |=> (trig_state == 2'd3 && !trig_pulse)); // R9

  AST_NOVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!smp_valid && !arm && !cancel && trig_state != 2'd3) |=> ($stable(trig_state) && !trig_pulse)); // R5

  AST_STAGE1_FROM_SEARCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trig_state == 2'd2) |-> ($past(trig_state) == 2'd1 || $past(trig_state) == 2'd2)); // R4
endmodule

bind seq_pattern_trigger seq_pattern_trigger_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .arm        (arm),
  .cancel     (cancel),
  .smp_valid  (smp_valid),
  .trig_pulse (trig_pulse),
  .trig_state (trig_state)
);

// File: tb/seq_pattern_trigger_test.sv
`timescale 1ns/1ps
module seq_pattern_trigger_test;
  localparam int W = 64;
  localparam logic [W-1:0] PA = 64'hA5A5_0001_DEAD_BEEF;
  localparam logic [W-1:0] PB = 64'h1234_5678_9ABC_DEF0;
  localparam logic [W-1:0] PC = 64'h0F0F_F0F0_0000_FFFF;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] smp_data, pat0, pat1, cmp_mask;
  logic smp_valid, arm, cancel;
  logic trig_pulse;
  logic [1:0] trig_state;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seq_pattern_trigger #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .pat0(pat0), .pat1(pat1), .cmp_mask(cmp_mask), .arm(arm), .cancel(cancel),
    .trig_pulse(trig_pulse), .trig_state(trig_state)
  );

  task automatic chk(input string req, input logic [1:0] es, input logic ep);
    n_chk++;
    if (trig_state !== es || trig_pulse !== ep) begin
      n_fail++;
      $display("FAIL %s: state=%0d pulse=%0b expected state=%0d pulse=%0b",
               req, trig_state, trig_pulse, es, ep);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // present one cycle of stimulus, then clear strobes
  task automatic cyc(input logic a, input logic c, input logic v, input logic [W-1:0] d);
    arm = a; cancel = c; smp_valid = v; smp_data = d;
    tick();
    arm = 1'b0; cancel = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic setup(input logic [W-1:0] p0, input logic [W-1:0] p1, input logic [W-1:0] m);
    pat0 = p0; pat1 = p1; cmp_mask = m;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; arm = 0; cancel = 0; smp_valid = 0; smp_data = '0;
    setup('0, '0, '0);
    repeat (3) tick();
    chk("R1 in reset", 2'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 after release", 2'd0, 1'b0);
  endtask

  task automatic t_idle();
    setup(PA, PB, '0);
    cyc(0, 0, 1, PA); cyc(0, 0, 1, PB);
    chk("R2 idle ignores samples", 2'd0, 1'b0);
  endtask

  task automatic t_basic();
    setup(PA, PB, ONES);
    cyc(1, 0, 0, '0);  chk("R2 arm", 2'd1, 1'b0);
    cyc(0, 0, 1, PC);  chk("R4 stage0 miss", 2'd1, 1'b0);
    cyc(0, 0, 0, PA);  chk("R5 invalid in stage0", 2'd1, 1'b0);
    cyc(0, 0, 1, PA);  chk("R4 stage0 hit", 2'd2, 1'b0);
    cyc(0, 0, 0, PB);  chk("R5 invalid in stage1", 2'd2, 1'b0);
    cyc(0, 0, 1, PB);  chk("R6 fire", 2'd3, 1'b1);
    cyc(0, 0, 1, PA);  chk("R6 pulse one cycle", 2'd3, 1'b0);
    cyc(0, 0, 1, PA);  cyc(0, 0, 1, PB);
    chk("R9 fired holds", 2'd3, 1'b0);
    cyc(1, 0, 0, '0);  chk("R9 rearm from fired", 2'd1, 1'b0);
    cyc(0, 1, 0, '0);
  endtask

  task automatic t_mask();
    logic [W-1:0] m;
    m = 64'h0000_0000_FFFF_0000;
    setup(64'hFFFF_FFFF_1234_FFFF, 64'h0000_0000_5678_0000, m);
    cyc(1, 0, 0, '0);
    cyc(0, 0, 1, 64'h0000_0001_1235_0000); chk("R3 masked bit differs", 2'd1, 1'b0);
    cyc(0, 0, 1, 64'hABCD_0000_1234_9999); chk("R3 unmasked bits ignored", 2'd2, 1'b0);
    cyc(0, 0, 1, 64'hFFFF_FFFF_5678_FFFF); chk("R8 shared mask on stage1", 2'd3, 1'b1);
    cyc(0, 1, 0, '0);
  endtask

  task automatic t_fallback();
    setup(PA, PB, ONES);
    cyc(1, 0, 0, '0);
    cyc(0, 0, 1, PA);  chk("R4 hit before fallback", 2'd2, 1'b0);
    cyc(0, 0, 1, PA);  chk("R7 miss returns to stage0", 2'd1, 1'b0);
    cyc(0, 0, 1, PA);  chk("R7 retest stage0", 2'd2, 1'b0);
    cyc(0, 0, 1, PB);  chk("R6 fire after fallback", 2'd3, 1'b1);
    cyc(0, 1, 0, '0);
  endtask

  task automatic t_cancel();
    setup(PA, PB, ONES);
    cyc(1, 0, 0, '0); cyc(0, 0, 1, PA);
    cyc(0, 1, 1, PB);  chk("R10 cancel in stage1", 2'd0, 1'b0);
    cyc(0, 0, 1, PA);  chk("R10 stays idle", 2'd0, 1'b0);
    cyc(1, 1, 0, '0);  chk("R10 cancel beats arm", 2'd0, 1'b0);
    cyc(1, 0, 0, '0); cyc(0, 0, 1, PA); cyc(0, 0, 1, PB);
    cyc(0, 1, 0, '0);  chk("R10 cancel from fired", 2'd0, 1'b0);
  endtask

  task automatic t_latch();
    setup(PA, PB, ONES);
    cyc(1, 0, 0, '0);
    setup(PC, PC, '0);
    cyc(0, 0, 1, PC);  chk("R11 new pat0 ignored", 2'd1, 1'b0);
    cyc(0, 0, 1, PA);  chk("R11 latched pat0 used", 2'd2, 1'b0);
    cyc(0, 0, 1, PB);  chk("R11 latched pat1 used", 2'd3, 1'b1);
    cyc(0, 1, 0, '0);
  endtask

  task automatic t_zero();
    setup(PA, PB, '0);
    cyc(1, 0, 0, '0);
    cyc(0, 0, 1, PC);  chk("R12 first sample", 2'd2, 1'b0);
    cyc(0, 0, 1, PC);  chk("R12 fires on second", 2'd3, 1'b1);
    cyc(0, 1, 0, '0);
  endtask

  task automatic t_rearm();
    setup(PA, PB, ONES);
    cyc(1, 0, 0, '0); cyc(0, 0, 1, PA);
    cyc(1, 0, 1, PB);  chk("R13 rearm in stage1", 2'd1, 1'b0);
    cyc(0, 0, 1, PB);  chk("R13 search restarted", 2'd1, 1'b0);
    cyc(0, 1, 0, '0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_basic();
    t_mask();
    t_fallback();
    t_cancel();
    t_latch();
    t_zero();
    t_rearm();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule